// File: doc/BRIEF.md
# Low-Power State and Reset Qualification Controller

This controller decides when the processor core, its peripherals and the crystal oscillator receive clocks. It qualifies a raw reset pin into an internal reset. Software asks for one of two sleep levels with a single-cycle request:

- **Light sleep (idle).** Only the core clock stops. Peripherals and the interrupt logic keep running. Any enabled interrupt or a reset ends it.
- **Deep sleep (power-down).** The oscillator is turned off. Only the reset pin brings the device back, and the oscillator gets a fixed settling interval before reset is released.

A reset pin pulse that wakes the core from light sleep has a short window before the reset qualifies. During that window the core runs again, but writes to on-chip RAM are blocked. The controller also holds the external-access strap. When the lock fuse is set, the strap is sampled during reset and held. When the fuse is clear, the live pin is passed through. A separate power-on input puts the whole block into reset.

Top module: `lpm_reset_ctrl`

## Requirements
- R1: Internal reset asserts only after the reset pin has been sampled high on 24 consecutive rising edges (2 machine cycles of 12 oscillator periods). It rises right after the 24th such edge. Any low sample restarts the count, so shorter pulses have no effect.
- R2: While power-on reset is low, internal reset is high. Once asserted, internal reset stays high while the pin stays high. It falls after the first edge that samples the pin low, unless settling (R7) is still in progress.
- R3: One edge after an idle request in run, the core clock enable is 0 while the peripheral and oscillator enables stay 1.
- R4: In idle, a nonzero interrupt vector (any bit) with the reset pin low returns the core clock enable to 1 after the next edge. An all-zero vector keeps the core stopped.
- R5: In idle, the edge that first samples the reset pin high turns the core clock enable and the RAM write inhibit on. The inhibit stays on until internal reset rises, and it falls in the same cycle. If the pin drops first, the block goes back to idle with the core stopped and the inhibit off.
- R6: One edge after a power-down request in run, the oscillator, peripheral and core enables are all 0. Interrupts then have no effect.
- R7: In power-down, the edge that samples the reset pin high asserts internal reset and the oscillator enable. The peripheral enable stays 0 for SETTLE_CYCLES (default 64) edges. Internal reset is then held at least one more cycle and is released as in R2.
- R8: When idle and power-down requests arrive together in run, power-down wins. A qualified reset wins over both.
- R9: With the lock input at 1, the strap output equals the strap pin sampled on the last edge of reset and holds it afterwards. With the lock input at 0, the output follows the pin directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstPin | input | 1 | Raw reset pin, active high, synchronous to oscClk |
| idleReq | input | 1 | Single-cycle request to enter idle |
| pdReq | input | 1 | Single-cycle request to enter power-down |
| irqVec | input | IRQ_W | Enabled interrupt requests |
| lockBit1 | input | 1 | Lock fuse: 1 selects the latched strap |
| eaPin | input | 1 | External-access strap pin |
| cpuClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| intRst | output | 1 | Qualified internal reset |
| ramWrInhibit | output | 1 | Blocks on-chip RAM writes during the idle-reset window |
| eaEff | output | 1 | Effective external-access strap |

## Verification
The assertions assume the following about the inputs:
- The reset pin is already synchronous to the oscillator clock.
- Sleep requests are one-cycle pulses issued only while the core runs.
- The lock fuse does not change in the same cycle that a reset ends.

The stimulus respects these assumptions: it changes every input half a period away from the rising edge, and it issues each request only from the run state. It also drops the reset pin early during settling, to show that the settle count, not the pin, holds reset in that case.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_WAKE   = 3'd2,
    ST_PDOWN  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_RESET  = 3'd5
  } lpmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic settleClr;
    logic settleRun;
    logic eaCapture;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic rstQualified;
    logic settleDone;
  } dpStatus_t;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int OSC_PER_MC    = 12,
  parameter int RST_MC        = 2,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       oscClk,
  input  logic       porN,
  input  logic       rstPin,
  input  logic       lockBit1,
  input  logic       eaPin,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status,
  output logic       eaEff
);

  localparam int PH_W = (OSC_PER_MC > 1) ? $clog2(OSC_PER_MC) : 1;
  localparam int MC_W = $clog2(RST_MC + 1);
  localparam int ST_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSC_PER_MC - 1);
  localparam logic [MC_W-1:0] MC_LAST = MC_W'(RST_MC - 1);
  localparam logic [MC_W-1:0] MC_FULL = MC_W'(RST_MC);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(SETTLE_CYCLES - 1);

  logic [PH_W-1:0] phase;
  logic [MC_W-1:0] mcCount;
  logic [ST_W-1:0] settleCnt;
  logic            eaHeld;
  logic            phaseWrap;

  assign phaseWrap = (phase == PH_LAST);

  // machine-cycle divider restarted whenever the pin is low
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      phase   <= '0;
      mcCount <= '0;
    end else if (!rstPin) begin
      phase   <= '0;
      mcCount <= '0;
    end else if (phaseWrap) begin
      phase <= '0;
      if (mcCount != MC_FULL) mcCount <= mcCount + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign status.rstQualified = rstPin &&
         ((mcCount == MC_FULL) || (phaseWrap && (mcCount == MC_LAST)));

  // oscillator settling counter
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN)                 settleCnt <= '0;
    else if (strobe.settleClr) settleCnt <= '0;
    else if (strobe.settleRun && settleCnt != ST_LAST) settleCnt <= settleCnt + 1'b1;
  end

  assign status.settleDone = strobe.settleRun && (settleCnt == ST_LAST);

  // strap capture during reset
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN)                 eaHeld <= 1'b0;
    else if (strobe.eaCapture) eaHeld <= eaPin;
  end

  assign eaEff = lockBit1 ? eaHeld : eaPin;

endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
#(
  parameter int IRQ_W = 6
) (
  input  logic             oscClk,
  input  logic             porN,
  input  logic             rstPin,
  input  logic             idleReq,
  input  logic             pdReq,
  input  logic [IRQ_W-1:0] irqVec,
  input  dpStatus_t        status,
  output ctlStrobe_t       strobe,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             oscEn,
  output logic             intRst,
  output logic             ramWrInhibit
);

  lpmState_t state, stateNext;

  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) state <= ST_RESET;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (status.rstQualified) stateNext = ST_RESET;
        else if (pdReq)          stateNext = ST_PDOWN;
        else if (idleReq)        stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        if (status.rstQualified) stateNext = ST_RESET;
        else if (rstPin)         stateNext = ST_WAKE;
        else if (|irqVec)        stateNext = ST_RUN;
      end
      ST_WAKE: begin
        if (status.rstQualified) stateNext = ST_RESET;
        else if (!rstPin)        stateNext = ST_IDLE;
      end
      ST_PDOWN: begin
        if (rstPin) stateNext = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (status.settleDone) stateNext = ST_RESET;
      end
      ST_RESET: begin
        if (!rstPin) stateNext = ST_RUN;
      end
      default: stateNext = ST_RESET;
    endcase
  end

  assign strobe.settleClr = (state == ST_PDOWN);
  assign strobe.settleRun = (state == ST_SETTLE);
  assign strobe.eaCapture = (state == ST_RESET);

  assign cpuClkEn     = (state == ST_RUN) || (state == ST_WAKE) || (state == ST_RESET);
  assign periphClkEn  = (state == ST_RUN) || (state == ST_IDLE) ||
                        (state == ST_WAKE) || (state == ST_RESET);
  assign oscEn        = (state != ST_PDOWN);
  assign intRst       = (state == ST_RESET) || (state == ST_SETTLE);
  assign ramWrInhibit = (state == ST_WAKE);

endmodule

// File: rtl/lpm_reset_ctrl.sv
module lpm_reset_ctrl
  import lpm_pkg::*;
#(
  parameter int IRQ_W         = 6,
  parameter int OSC_PER_MC    = 12,
  parameter int RST_MC        = 2,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic             oscClk,
  input  logic             porN,
  input  logic             rstPin,
  input  logic             idleReq,
  input  logic             pdReq,
  input  logic [IRQ_W-1:0] irqVec,
  input  logic             lockBit1,
  input  logic             eaPin,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             oscEn,
  output logic             intRst,
  output logic             ramWrInhibit,
  output logic             eaEff
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  lpm_control #(.IRQ_W(IRQ_W)) u_ctl (
    .oscClk       (oscClk),
    .porN         (porN),
    .rstPin       (rstPin),
    .idleReq      (idleReq),
    .pdReq        (pdReq),
    .irqVec       (irqVec),
    .status       (status),
    .strobe       (strobe),
    .cpuClkEn     (cpuClkEn),
    .periphClkEn  (periphClkEn),
    .oscEn        (oscEn),
    .intRst       (intRst),
    .ramWrInhibit (ramWrInhibit)
  );

  lpm_datapath #(
    .OSC_PER_MC    (OSC_PER_MC),
    .RST_MC        (RST_MC),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .oscClk   (oscClk),
    .porN     (porN),
    .rstPin   (rstPin),
    .lockBit1 (lockBit1),
    .eaPin    (eaPin),
    .strobe   (strobe),
    .status   (status),
    .eaEff    (eaEff)
  );

endmodule

// File: rtl/lpm_reset_ctrl_chk.sv
module lpm_reset_ctrl_chk #(
  parameter int IRQ_W = 6
) (
  input logic             oscClk,
  input logic             porN,
  input logic             rstPin,
  input logic [IRQ_W-1:0] irqVec,
  input logic             lockBit1,
  input logic             cpuClkEn,
  input logic             periphClkEn,
  input logic             oscEn,
  input logic             intRst,
  input logic             ramWrInhibit,
  input logic             eaEff
);

  // R1: a rising internal reset always follows a high pin sample
  a_r1_rise_needs_pin: assert property (@(posedge oscClk) disable iff (!porN)
    $rose(intRst) |-> $past(rstPin));

  // R2: internal reset only drops after a low pin sample
  a_r2_release_on_low: assert property (@(posedge oscClk) disable iff (!porN)
    $fell(intRst) |-> !$past(rstPin));

  // R4: idle plus an interrupt restarts the core clock
  a_r4_irq_wakes: assert property (@(posedge oscClk) disable iff (!porN)
    (!cpuClkEn && oscEn && periphClkEn && (|irqVec)) |=> cpuClkEn);

  // R5: the RAM-write window only exists with the core running and out of reset
  a_r5_inhibit_window: assert property (@(posedge oscClk) disable iff (!porN)
    ramWrInhibit |-> (cpuClkEn && !intRst));

  // R6: oscillator off means every clock is off
  a_r6_pdown_quiet: assert property (@(posedge oscClk) disable iff (!porN)
    !oscEn |-> (!cpuClkEn && !periphClkEn));

  // R7: internal reset is never asserted with the oscillator stopped
  a_r7_reset_osc_on: assert property (@(posedge oscClk) disable iff (!porN)
    intRst |-> oscEn);

  // R9: latched strap stays put outside reset
  a_r9_strap_held: assert property (@(posedge oscClk) disable iff (!porN)
    (lockBit1 && $past(lockBit1) && !intRst && !$past(intRst)) |-> $stable(eaEff));

endmodule

bind lpm_reset_ctrl lpm_reset_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .oscClk       (oscClk),
  .porN         (porN),
  .rstPin       (rstPin),
  .irqVec       (irqVec),
  .lockBit1     (lockBit1),
  .cpuClkEn     (cpuClkEn),
  .periphClkEn  (periphClkEn),
  .oscEn        (oscEn),
  .intRst       (intRst),
  .ramWrInhibit (ramWrInhibit),
  .eaEff        (eaEff)
);

// File: tb/tb_lpm_reset_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_reset_ctrl;

  localparam int IRQ_W  = 6;
  localparam int QUAL   = 24;
  localparam int SETTLE = 64;

  logic             oscClk = 1'b0;
  logic             porN = 1'b0;
  logic             rstPin = 1'b1;
  logic             idleReq = 1'b0;
  logic             pdReq = 1'b0;
  logic [IRQ_W-1:0] irqVec = '0;
  logic             lockBit1 = 1'b0;
  logic             eaPin = 1'b0;
  logic cpuClkEn, periphClkEn, oscEn, intRst, ramWrInhibit, eaEff;

  int checks = 0;
  int failures = 0;

  always #10 oscClk = ~oscClk;

  lpm_reset_ctrl dut (
    .oscClk(oscClk), .porN(porN), .rstPin(rstPin), .idleReq(idleReq),
    .pdReq(pdReq), .irqVec(irqVec), .lockBit1(lockBit1), .eaPin(eaPin),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
    .intRst(intRst), .ramWrInhibit(ramWrInhibit), .eaEff(eaEff)
  );

  task automatic step(input int n);
    repeat (n) @(negedge oscClk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_idle();
    idleReq = 1'b1; step(1); idleReq = 1'b0;
  endtask

  task automatic t_reset_state();
    step(3);
    chk("R2 por intRst", intRst, 1'b1);
    chk("R2 por oscEn", oscEn, 1'b1);
    chk("R2 por inhibit", ramWrInhibit, 1'b0);
    porN = 1'b1; step(2);
    chk("R2 held while pin high", intRst, 1'b1);
    rstPin = 1'b0; step(1);
    chk("R2 release", intRst, 1'b0);
    chk("R2 core runs", cpuClkEn, 1'b1);
  endtask

  task automatic t_qualify();
    rstPin = 1'b1; step(QUAL - 1);
    chk("R1 not before 24", intRst, 1'b0);
    step(1);
    chk("R1 asserted at 24", intRst, 1'b1);
    step(5);
    chk("R2 stays while high", intRst, 1'b1);
    rstPin = 1'b0; step(1);
    chk("R2 falls after low", intRst, 1'b0);
  endtask

  task automatic t_short_pulses();
    logic seen = 1'b0;
    for (int k = 0; k < 3; k++) begin
      rstPin = 1'b1;
      for (int i = 0; i < QUAL - 1; i++) begin step(1); seen |= intRst; end
      rstPin = 1'b0; step(1); seen |= intRst;
    end
    chk("R1 short pulses ignored", seen, 1'b0);
    chk("R1 core still running", cpuClkEn, 1'b1);
  endtask

  task automatic t_idle_irq();
    pulse_idle();
    chk("R3 core stopped", cpuClkEn, 1'b0);
    chk("R3 periph on", periphClkEn, 1'b1);
    chk("R3 osc on", oscEn, 1'b1);
    step(5);
    chk("R4 no irq stays idle", cpuClkEn, 1'b0);
    irqVec = 6'b000100; step(1); irqVec = '0;
    chk("R4 irq wakes", cpuClkEn, 1'b1);
    pulse_idle();
    irqVec = 6'b100000; step(1); irqVec = '0;
    chk("R4 top irq bit wakes", cpuClkEn, 1'b1);
  endtask

  task automatic t_idle_reset_window();
    pulse_idle();
    rstPin = 1'b1; step(1);
    chk("R5 window core on", cpuClkEn, 1'b1);
    chk("R5 window inhibit", ramWrInhibit, 1'b1);
    chk("R5 window no reset yet", intRst, 1'b0);
    step(QUAL - 2);
    chk("R5 inhibit before qualify", ramWrInhibit, 1'b1);
    step(1);
    chk("R5 reset takes over", intRst, 1'b1);
    chk("R5 inhibit drops", ramWrInhibit, 1'b0);
    rstPin = 1'b0; step(1);
    chk("R2 run after window reset", intRst, 1'b0);
    // aborted window
    pulse_idle();
    rstPin = 1'b1; step(3);
    chk("R5 abort window open", ramWrInhibit, 1'b1);
    rstPin = 1'b0; step(1);
    chk("R5 abort back to idle", cpuClkEn, 1'b0);
    chk("R5 abort inhibit off", ramWrInhibit, 1'b0);
    irqVec = 6'b000001; step(1); irqVec = '0;
    chk("R4 wake after abort", cpuClkEn, 1'b1);
  endtask

  task automatic t_pdown();
    pdReq = 1'b1; step(1); pdReq = 1'b0;
    chk("R6 osc off", oscEn, 1'b0);
    chk("R6 periph off", periphClkEn, 1'b0);
    chk("R6 core off", cpuClkEn, 1'b0);
    irqVec = '1; step(3); irqVec = '0;
    chk("R6 irq ignored", oscEn, 1'b0);
    rstPin = 1'b1; step(1); rstPin = 1'b0;
    chk("R7 reset on exit", intRst, 1'b1);
    chk("R7 osc on", oscEn, 1'b1);
    chk("R7 periph settling", periphClkEn, 1'b0);
    step(SETTLE - 1);
    chk("R7 still settling", periphClkEn, 1'b0);
    chk("R7 reset during settle", intRst, 1'b1);
    step(1);
    chk("R7 settle done periph", periphClkEn, 1'b1);
    chk("R7 reset extra cycle", intRst, 1'b1);
    step(1);
    chk("R7 released", intRst, 1'b0);
  endtask

  task automatic t_priority();
    idleReq = 1'b1; pdReq = 1'b1; step(1); idleReq = 1'b0; pdReq = 1'b0;
    chk("R8 pdown wins", oscEn, 1'b0);
    rstPin = 1'b1; step(1); rstPin = 1'b0;
    step(SETTLE + 1);
    chk("R8 recovered", intRst, 1'b0);
    // qualified reset beats a request in the same edge
    rstPin = 1'b1; step(QUAL - 1);
    pdReq = 1'b1; step(1); pdReq = 1'b0;
    chk("R8 reset beats pdown", intRst, 1'b1);
    chk("R8 osc kept", oscEn, 1'b1);
    rstPin = 1'b0; step(1);
  endtask

  task automatic t_strap();
    lockBit1 = 1'b1; eaPin = 1'b1;
    rstPin = 1'b1; step(QUAL + 2);
    rstPin = 1'b0; step(1);
    eaPin = 1'b0; step(2);
    chk("R9 latched one", eaEff, 1'b1);
    lockBit1 = 1'b0; #1;
    chk("R9 unlocked follows pin", eaEff, 1'b0);
    eaPin = 1'b1; #1;
    chk("R9 unlocked follows pin high", eaEff, 1'b1);
    step(1);
    eaPin = 1'b0; lockBit1 = 1'b1;
    rstPin = 1'b1; step(QUAL + 2);
    rstPin = 1'b0; step(1);
    eaPin = 1'b1; step(3);
    chk("R9 latched zero", eaEff, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_qualify();
    t_short_pulses();
    t_idle_irq();
    t_idle_reset_window();
    t_pdown();
    t_priority();
    t_strap();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge oscClk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule